// File: doc/BRIEF.md
# Calibrated SAR conversion controller

This block sequences a successive-approximation converter. Every clock cycle it presents a trial code to the main binary-weighted DAC, reads one comparator decision and refines the code one bit at a time, from the top bit down. Once the least significant bit has been decided, the finished word is published with a one-cycle done pulse.

The top few capacitors of the main array are not trusted to be exactly binary. The block therefore keeps a signed correction code for each of them and drives a separate correction DAC port. In conversion mode that port carries the clamped sum of the corrections whose main-DAC bits are currently set, trial bits included. The codes are measured by a calibration run. A run starts by itself after reset, or in idle when software requests one. Each capacitor is measured many times with its own short binary search, the results are accumulated in a signed register, and the average replaces the stored code. Conversion requests are refused while a run is in progress.

Top module: `sar_cal_ctrl`

## Requirements
- R1: When `start_i` is sampled high while the block is idle, the next trial code on `dac_code_o` is midscale: bit DAC_BITS-1 set and all lower bits clear.
- R2: For each decision, `cmp_i` = 1 keeps the trial bit and `cmp_i` = 0 clears it. The next lower bit is then set as the new trial bit.
- R3: A conversion takes exactly DAC_BITS decision edges after the start edge, and `busy_o` stays high during them. If the comparator reports 1 exactly when `dac_code_o` <= V, then `result_o` = V.
- R4: `start_i` is ignored while a conversion or a calibration run is active. No extra conversion and no extra done pulse follow.
- R5: `done_o` is high for exactly one cycle, on the edge after the last decision. `result_o` changes only on that edge and holds its value until the next done.
- R6: During a conversion, `cor_code_o` is the two's-complement sum of the stored codes i (i = 0..CAL_CAPS-1) whose bit DAC_BITS-CAL_CAPS+i is set in `dac_code_o`, clamped to the range -2^(COR_W-1) to 2^(COR_W-1)-1.
- R7: With AUTO_CAL = 1, a calibration run is active from reset onward: `cal_active_o` and `busy_o` are high and `done_o` is low.
- R8: `cal_req_i` sampled high while the block is idle starts a calibration run. If `start_i` is high in the same cycle, the calibration wins and no conversion starts.
- R9: A run measures capacitors 0 to CAL_CAPS-1 in ascending order. Each capacitor gets 2^REP_LOG2 back-to-back measurements of COR_W decision cycles, so a run lasts CAL_CAPS*2^REP_LOG2*COR_W cycles. During a measurement, `dac_code_o` is one-hot on bit DAC_BITS-CAL_CAPS+i, and `cor_code_o` carries the signed trial correction, which is 0 at the first decision of each measurement. `cmp_i` = 1 keeps the trial bit of that search, with the search run on the code whose sign bit is inverted.
- R10: After a run, stored code i equals floor(sum of its measured codes / 2^REP_LOG2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle conversion request |
| cal_req_i | input | 1 | One-cycle calibration request |
| cmp_i | input | 1 | Comparator decision for the current trial |
| dac_code_o | output | DAC_BITS | Main DAC code |
| cor_code_o | output | COR_W | Signed correction DAC code |
| busy_o | output | 1 | Conversion or calibration in progress |
| cal_active_o | output | 1 | Calibration run in progress |
| done_o | output | 1 | One-cycle pulse with a new result |
| result_o | output | DAC_BITS | Last conversion result |

## Verification
The hardest behaviour to reach from the ports is the averaging. It only shows up if the comparator answers differently across the repeated measurements of one capacitor, and each stored value becomes visible only later, through the correction port during conversions. The bench counts decision cycles from the start of each run, which tells it the capacitor and repetition under way. It drives a threshold that alternates between repetitions, so each average lands on a half step and exposes the floor. Every input code is then converted, which reaches every combination of the calibrated bits, including those where the sum saturates in either direction.

// File: rtl/sar_cal_pkg.sv
// Package: shared types for the calibrated SAR controller.
// Assumes: nothing beyond standard SystemVerilog.
package sar_cal_pkg;

    // Operating mode, derived from which search engine is active
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_CONV = 2'd1,
        MODE_CAL  = 2'd2
    } sar_mode_e;

endpackage

// File: rtl/sar_search.sv
// Module: sar_search
// Binary search register. Each active cycle it decides the bit under
// trial from cmp_i and then sets the next lower bit. A load restarts it
// at midscale. It runs W decisions and then goes idle.
// Assumes: W >= 2. A load has priority over a decision in the same cycle.
module sar_search #(
    parameter int W              = 8,
    parameter bit START_ON_RESET = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         cmp_i,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] decided_o,
    output logic         active_o,
    output logic         last_o
);
    localparam int IW = $clog2(W);
    localparam logic [W-1:0]  MID = {1'b1, {(W-1){1'b0}}};
    localparam logic [IW-1:0] TOP = IW'(W-1);

    logic [W-1:0]  trial_q;
    logic [W-1:0]  trial_nxt;
    logic [W-1:0]  decided;
    logic [IW-1:0] idx_q;
    logic          active_q;

    // Apply the decision to the bit under trial and arm the next bit
    always_comb begin
        decided      = trial_q;
        decided[idx_q] = cmp_i;
        trial_nxt    = decided;
        if (idx_q != '0) begin
            trial_nxt[idx_q - 1'b1] = 1'b1;
        end
    end

    // Trial register, bit pointer and activity flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_q  <= MID;
            idx_q    <= TOP;
            active_q <= START_ON_RESET;
        end else if (load_i) begin
            trial_q  <= MID;
            idx_q    <= TOP;
            active_q <= 1'b1;
        end else if (active_q) begin
            trial_q <= trial_nxt;
            if (idx_q == '0) begin
                active_q <= 1'b0;
            end else begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    assign trial_o   = trial_q;
    assign decided_o = decided;
    assign active_o  = active_q;
    assign last_o    = active_q && (idx_q == '0);

    // R1
    load_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (trial_o == MID) && active_o);

    // R3
    keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !last_o) |=> active_o);

endmodule

// File: rtl/cal_seq.sv
// Module: cal_seq
// Calibration sequencer. It walks the calibrated capacitors in ascending
// order. For each one it accumulates 2^REP_LOG2 signed measurements and
// stores the accumulator shifted right arithmetically by REP_LOG2.
// Assumes: meas_last_i marks the final decision of a measurement, and
// meas_code_i is valid in that cycle. Stored codes clear on reset.
module cal_seq #(
    parameter int CAL      = 4,
    parameter int CW       = 6,
    parameter int REP_LOG2 = 8,
    parameter bit AUTO     = 1'b1,
    localparam int CAPW    = (CAL > 1) ? $clog2(CAL) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    meas_last_i,
    input  logic [CW-1:0]           meas_code_i,
    output logic                    active_o,
    output logic [CAPW-1:0]         cap_o,
    output logic                    more_o,
    output logic [CAL-1:0][CW-1:0]  codes_o
);
    localparam int AW = CW + REP_LOG2;

    logic                  active_q;
    logic [CAPW-1:0]       cap_q;
    logic [REP_LOG2-1:0]   rep_q;
    logic signed [AW-1:0]  acc_q;
    logic signed [AW-1:0]  acc_sum;
    logic                  last_rep;
    logic                  last_cap;
    logic                  store;

    // Running sum including the measurement finishing this cycle
    assign acc_sum  = acc_q + {{REP_LOG2{meas_code_i[CW-1]}}, meas_code_i};
    assign last_rep = &rep_q;
    assign last_cap = (cap_q == CAPW'(CAL - 1));
    assign store    = active_q && meas_last_i && last_rep;

    // Capacitor pointer, repetition counter and accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= AUTO;
            cap_q    <= '0;
            rep_q    <= '0;
            acc_q    <= '0;
        end else if (start_i && !active_q) begin
            active_q <= 1'b1;
            cap_q    <= '0;
            rep_q    <= '0;
            acc_q    <= '0;
        end else if (active_q && meas_last_i) begin
            rep_q <= rep_q + 1'b1;
            if (last_rep) begin
                acc_q <= '0;
                if (last_cap) begin
                    active_q <= 1'b0;
                end else begin
                    cap_q <= cap_q + 1'b1;
                end
            end else begin
                acc_q <= acc_sum;
            end
        end
    end

    // One stored correction per calibrated capacitor
    for (genvar g = 0; g < CAL; g++) begin : g_store
        logic [CW-1:0] code_q;
        // Replace the code with the new average at the end of its measurements
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q <= '0;
            end else if (store && (cap_q == CAPW'(g))) begin
                code_q <= acc_sum[AW-1:REP_LOG2];
            end
        end
        assign codes_o[g] = code_q;
    end

    assign active_o = active_q;
    assign cap_o    = cap_q;
    assign more_o   = active_q && meas_last_i && !(last_rep && last_cap);

    // R9
    run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store && last_cap) |=> !active_o);

    // R9
    run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !active_o) |=> active_o && (cap_o == '0));

endmodule

// File: rtl/cor_sum.sv
// Module: cor_sum
// Adds the signed corrections whose select bits are set and clamps the
// total to the signed CW-bit range.
// Assumes: purely combinational, CAL >= 1.
module cor_sum #(
    parameter int CAL = 4,
    parameter int CW  = 6
) (
    input  logic [CAL-1:0]          sel_i,
    input  logic [CAL-1:0][CW-1:0]  codes_i,
    output logic [CW-1:0]           cor_o
);
    localparam int SW = CW + $clog2(CAL + 1) + 1;
    localparam logic signed [SW-1:0] MAXV = {{(SW-CW+1){1'b0}}, {(CW-1){1'b1}}};
    localparam logic signed [SW-1:0] MINV = {{(SW-CW+1){1'b1}}, {(CW-1){1'b0}}};

    logic signed [SW-1:0] total;

    // Wide signed sum of the selected corrections
    always_comb begin
        total = '0;
        for (int i = 0; i < CAL; i++) begin
            if (sel_i[i]) begin
                total = total + {{(SW-CW){codes_i[i][CW-1]}}, codes_i[i]};
            end
        end
    end

    // Clamp to the correction DAC range
    always_comb begin
        if (total > MAXV) begin
            cor_o = MAXV[CW-1:0];
        end else if (total < MINV) begin
            cor_o = MINV[CW-1:0];
        end else begin
            cor_o = total[CW-1:0];
        end
    end

endmodule

// File: rtl/sar_cal_ctrl.sv
// Module: sar_cal_ctrl (top)
// Calibrated SAR conversion controller. One search engine runs the
// main-DAC conversion and a second one measures the correction codes.
// A sequencer averages the measurements and stores them, and a clamped
// adder forms the correction DAC output from the active bits.
// Assumes: a synchronous active-low reset held for at least two cycles.
// The comparator decision for the current trial is valid at each edge.
module sar_cal_ctrl
    import sar_cal_pkg::*;
#(
    parameter int DAC_BITS = 8,
    parameter int CAL_CAPS = 4,
    parameter int COR_W    = 6,
    parameter int REP_LOG2 = 8,
    parameter bit AUTO_CAL = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cal_req_i,
    input  logic                cmp_i,
    output logic [DAC_BITS-1:0] dac_code_o,
    output logic [COR_W-1:0]    cor_code_o,
    output logic                busy_o,
    output logic                cal_active_o,
    output logic                done_o,
    output logic [DAC_BITS-1:0] result_o
);
    localparam int LOW  = DAC_BITS - CAL_CAPS;
    localparam int CAPW = (CAL_CAPS > 1) ? $clog2(CAL_CAPS) : 1;
    localparam logic [COR_W-1:0] SIGN = {1'b1, {(COR_W-1){1'b0}}};

    logic [DAC_BITS-1:0]         conv_trial, conv_dec;
    logic                        conv_active, conv_last;
    logic [COR_W-1:0]            cal_trial, cal_dec;
    logic                        cal_active, cal_last, cal_more;
    logic [CAPW-1:0]             cap;
    logic [CAL_CAPS-1:0][COR_W-1:0] codes;
    logic [COR_W-1:0]            conv_cor;
    logic [DAC_BITS-1:0]         cal_dac;
    logic                        idle, cal_go, conv_go;
    logic                        done_q;
    logic [DAC_BITS-1:0]         result_q;
    sar_mode_e                   mode;

    // Request arbitration: calibration beats conversion and both need idle
    assign idle    = !conv_active && !cal_active;
    assign cal_go  = cal_req_i && idle;
    assign conv_go = start_i && idle && !cal_req_i;

    sar_search #(.W(DAC_BITS), .START_ON_RESET(1'b0)) i_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (conv_go),
        .cmp_i     (cmp_i),
        .trial_o   (conv_trial),
        .decided_o (conv_dec),
        .active_o  (conv_active),
        .last_o    (conv_last)
    );

    sar_search #(.W(COR_W), .START_ON_RESET(AUTO_CAL)) i_meas (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (cal_go || cal_more),
        .cmp_i     (cmp_i),
        .trial_o   (cal_trial),
        .decided_o (cal_dec),
        .active_o  (),
        .last_o    (cal_last)
    );

    cal_seq #(.CAL(CAL_CAPS), .CW(COR_W), .REP_LOG2(REP_LOG2), .AUTO(AUTO_CAL)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (cal_go),
        .meas_last_i (cal_last),
        .meas_code_i (cal_dec ^ SIGN),
        .active_o    (cal_active),
        .cap_o       (cap),
        .more_o      (cal_more),
        .codes_o     (codes)
    );

    cor_sum #(.CAL(CAL_CAPS), .CW(COR_W)) i_sum (
        .sel_i   (conv_trial[DAC_BITS-1:LOW]),
        .codes_i (codes),
        .cor_o   (conv_cor)
    );

    // One-hot main-DAC code for the capacitor under measurement
    always_comb begin
        cal_dac = '0;
        for (int b = 0; b < CAL_CAPS; b++) begin
            cal_dac[LOW + b] = (cap == CAPW'(b));
        end
    end

    // Current mode for output steering
    always_comb begin
        if (cal_active)       mode = MODE_CAL;
        else if (conv_active) mode = MODE_CONV;
        else                  mode = MODE_IDLE;
    end

    // Output steering by mode
    always_comb begin
        case (mode)
            MODE_CAL: begin
                dac_code_o = cal_dac;
                cor_code_o = cal_trial ^ SIGN;
            end
            default: begin
                dac_code_o = conv_trial;
                cor_code_o = conv_cor;
            end
        endcase
    end

    // Result register and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= conv_last;
            if (conv_last) begin
                result_q <= conv_dec;
            end
        end
    end

    assign busy_o       = !idle;
    assign cal_active_o = cal_active;
    assign done_o       = done_q;
    assign result_o     = result_q;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R4
    no_conv_in_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_active_o |-> !conv_active);

    // R8
    cal_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_req_i && !busy_o) |=> cal_active_o && !conv_active);

endmodule

// File: tb/test_sar_cal_ctrl.sv
module test_sar_cal_ctrl;
    localparam int N   = 8;
    localparam int M   = 4;
    localparam int W   = 6;
    localparam int RL  = 8;
    localparam int REP = 1 << RL;
    localparam int LOW = N - M;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic cal_req_i = 1'b0;
    logic cmp_i = 1'b0;
    logic [N-1:0] dac_code_o;
    logic [W-1:0] cor_code_o;
    logic busy_o, cal_active_o, done_o;
    logic [N-1:0] result_o;

    int vectors = 0;
    int errors = 0;
    int tgt [M];
    int expc [M];

    always #5 clk = ~clk;

    sar_cal_ctrl #(.DAC_BITS(N), .CAL_CAPS(M), .COR_W(W), .REP_LOG2(RL), .AUTO_CAL(1'b1))
    i_sar_cal_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_req_i(cal_req_i),
        .cmp_i(cmp_i), .dac_code_o(dac_code_o), .cor_code_o(cor_code_o),
        .busy_o(busy_o), .cal_active_o(cal_active_o), .done_o(done_o),
        .result_o(result_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int scor();
        return int'($signed(cor_code_o));
    endfunction

    // Expected correction for a main code: clamped sum of active codes (R6)
    function automatic int sat_sum(input int code);
        int s = 0;
        for (int i = 0; i < M; i++) if (code[LOW + i]) s += expc[i];
        if (s > (1 << (W-1)) - 1) s = (1 << (W-1)) - 1;
        if (s < -(1 << (W-1))) s = -(1 << (W-1));
        return s;
    endfunction

    // Drive a calibration run from the current negedge; stray start at start_at
    task automatic cal_run(input int start_at);
        int c = 0;
        bit seen_done = 0;
        while (cal_active_o && c < M*REP*W + 10) begin
            int meas = c / W;
            int rep = meas % REP;
            int cap = meas / REP;
            int target;
            if (cap >= M) cap = M - 1;
            if (c % W == 0) begin
                chk(dac_code_o == N'(1 << (LOW + cap)), "R9 dac one-hot", int'(dac_code_o), 1 << (LOW + cap));
                chk(scor() == 0, "R9 first trial", scor(), 0);
            end
            if (done_o) seen_done = 1;
            target = tgt[cap] + ((rep % 2 == 0) ? 2 : -1);
            cmp_i = (scor() <= target);
            start_i = (c == start_at);
            c++;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(c == M*REP*W, "R9 run length", c, M*REP*W);
        // R10: floor of the average of the measured values
        for (int i = 0; i < M; i++) begin
            int s = (REP/2) * (tgt[i] + 2) + (REP/2) * (tgt[i] - 1);
            expc[i] = s >>> RL;
        end
        for (int k = 0; k < 3; k++) begin
            if (done_o) seen_done = 1;
            chk(busy_o == 0, "R4 idle after run", int'(busy_o), 0);
            @(negedge clk);
        end
        chk(seen_done == 0, "R4 start ignored during calibration", int'(seen_done), 0);
    endtask

    // One conversion of value vin; stray start pulse at step glitch (-1: none)
    task automatic convert(input int vin, input int glitch);
        int prev = int'(result_o);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int j = N - 1; j >= 0; j--) begin
            int et = (vin & ~((1 << (j + 1)) - 1)) | (1 << j);
            chk(int'(dac_code_o) == et, (j == N-1) ? "R1 midscale" : "R2 trial code", int'(dac_code_o), et);
            chk(scor() == sat_sum(int'(dac_code_o)), "R6 correction sum", scor(), sat_sum(int'(dac_code_o)));
            chk(busy_o && !done_o, "R3 busy during decisions", int'(busy_o), 1);
            if (j == N/2) chk(int'(result_o) == prev, "R5 result held", int'(result_o), prev);
            cmp_i = (int'(dac_code_o) <= vin);
            start_i = (j == glitch);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, "R3 done after N decisions", int'(done_o), 1);
        chk(int'(result_o) == vin, "R3 result", int'(result_o), vin);
        chk(busy_o == 1'b0, "R3 idle at done", int'(busy_o), 0);
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R4/R5 single pulse, no restart", int'(done_o), 0);
        chk(int'(result_o) == vin, "R5 result kept", int'(result_o), vin);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        vectors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        tgt[0] = 20; tgt[1] = 15; tgt[2] = -18; tgt[3] = -25;
        for (int i = 0; i < M; i++) expc[i] = 0;
        repeat (3) @(negedge clk);
        // Reset state (R7, R9)
        chk(busy_o && cal_active_o, "R7 calibration from reset", int'(cal_active_o), 1);
        chk(done_o == 1'b0, "R7 no done in reset", int'(done_o), 0);
        chk(result_o == '0, "R5 reset result", int'(result_o), 0);
        chk(dac_code_o == N'(1 << LOW), "R9 reset dac", int'(dac_code_o), 1 << LOW);
        chk(scor() == 0, "R9 reset correction", scor(), 0);
        rst_n = 1'b1;
        cal_run(100);
        // Full sweep of input codes with stray starts (R1-R6)
        for (int v = 0; v < (1 << N); v++) begin
            convert(v, (v % 3 == 0) ? -1 : v % N);
        end
        // Recalibration by request, with start in the same cycle (R8)
        tgt[0] = 29; tgt[1] = -31; tgt[2] = 0; tgt[3] = -1;
        cal_req_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        cal_req_i = 1'b0;
        start_i = 1'b0;
        chk(cal_active_o && busy_o, "R8 calibration wins", int'(cal_active_o), 1);
        cal_run(-1);
        for (int v = 0; v < (1 << N); v += 7) begin
            convert(v, -1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule